// File: doc/BRIEF.md
# I2C Channel Selection Switch Controller

This block is an I2C target that holds a single control byte. The low four bits of that byte choose which downstream bus segments are joined to the upstream bus. The block samples SCL and SDA with a fast system clock. Both lines pass through a synchronizer and a glitch filter. The block then finds start and stop conditions and shifts in the address and data bytes. It pulls SDA low through an open-drain enable to send acknowledges and read data. The pass gates are outside the block. Only the per-channel enable outputs represent them.

A master addresses the block with the 7-bit address `1110` followed by the three strap pins. In a write, the master sends one or more bytes. Each byte replaces the previous one, but the new selection is only held pending. The enables change at the next stop condition, so a segment is never joined in the middle of a transfer. In a read, the master gets the current selection back in one byte. An active-low reset deselects every channel, drops any pending write and abandons the transfer in progress.

Top module: `i2c_chan_select`

## Requirements
- R1: While and after reset, `chan_en` is 0 and `sda_oe` is 0. The bus logic returns to idle.
- R2: The block acknowledges only when the 7-bit address equals `{4'b1110, addr_pins}`, sent MSB first, with the R/W bit last (1 = read). On a mismatch it sends no acknowledge and ignores the bus until the next start or stop, so `chan_en` is left unchanged.
- R3: A byte written after an acknowledged write address does not change `chan_en` before the following stop condition.
- R4: When several data bytes arrive in one write, the last one before the stop takes effect.
- R5: After the stop, `chan_en[i]` equals bit i of the kept byte, for i = 0..3, in any combination. Bits 7..4 have no effect.
- R6: A read returns `{4'b0000, chan_en}` MSB first. If the master acknowledges the byte, the same value is sent again.
- R7: The acknowledge drives SDA low for the whole high phase of the ninth clock. SDA is released after SCL falls again.
- R8: A repeated start restarts address reception without applying the pending selection. A read issued after the repeated start still returns the old value, and the next stop applies the pending byte.
- R9: Asserting `rst_n` during a write clears the pending byte and releases SDA. A stop that follows leaves every channel deselected.
- R10: Pulses on SCL or SDA shorter than `FILT_LEN` system clocks are ignored. This includes an SDA dip while SCL is high, which would otherwise look like a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_pins | input | 3 | Strap pins forming the low three address bits |
| scl_in | input | 1 | Upstream SCL level |
| sda_in | input | 1 | Upstream SDA level (wired-AND bus) |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| chan_en | output | 4 | Per-channel connect enables |

## Verification
Directed writes use several nibble patterns, including one with the upper bits set. This tells a masked register apart from one that passes the whole byte through. A multi-byte write distinguishes last-wins from first-wins. A deliberately mismatched address and a repeated start separate a correct address compare and stop-only commit from eager designs. A transfer with spikes on both lines shows whether the filter rejects short pulses. Random transfers then mix strap values, address hits and misses, byte counts and reads, and each result is checked against a bench model of the selection.

// File: rtl/i2c_chan_select.sv
module i2c_chan_select #(
  parameter int         NCHAN      = 4,
  parameter int         FILT_LEN   = 4,
  parameter logic [3:0] ADDR_FIXED = 4'b1110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr_pins,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic [NCHAN-1:0] chan_en
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_ACKA = 3'd2, S_WDAT = 3'd3,
                         S_ACKW = 3'd4, S_RDAT = 3'd5, S_RACK = 3'd6, S_IGN  = 3'd7;

  logic [1:0]       s1, s2, flt, flt_d;
  logic [CW-1:0]    fcnt [2];
  logic [2:0]       st;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic             rw, mack, pend_v;
  logic [NCHAN-1:0] pend;
  logic             scl_f, sda_f, start_det, stop_det, scl_rise, scl_fall;
  logic [7:0]       tx;

  assign scl_f     = flt[0];
  assign sda_f     = flt[1];
  assign start_det = scl_f & flt_d[0] & flt_d[1] & ~sda_f;
  assign stop_det  = scl_f & flt_d[0] & ~flt_d[1] & sda_f;
  assign scl_rise  = scl_f & ~flt_d[0];
  assign scl_fall  = ~scl_f & flt_d[0];
  assign tx        = 8'(chan_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= '1;
      s2    <= '1;
      flt   <= '1;
      flt_d <= '1;
      for (int i = 0; i < 2; i++) fcnt[i] <= '0;
    end else begin
      s1    <= {sda_in, scl_in};
      s2    <= s1;
      flt_d <= flt;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] == flt[i]) fcnt[i] <= '0;
        else if (fcnt[i] == CW'(FILT_LEN - 1)) begin
          flt[i]  <= s2[i];
          fcnt[i] <= '0;
        end else fcnt[i] <= fcnt[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      pend_v  <= 1'b0;
      pend    <= '0;
      sda_oe  <= 1'b0;
      chan_en <= '0;
    end else if (start_det) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
      if (pend_v) begin
        chan_en <= pend;
        pend_v  <= 1'b0;
      end
    end else if (scl_rise) begin
      case (st)
        S_ADDR, S_WDAT: begin
          shreg  <= {shreg[6:0], sda_f};
          bitcnt <= bitcnt + 1'b1;
        end
        S_RDAT: bitcnt <= bitcnt + 1'b1;
        S_RACK: mack <= ~sda_f;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st)
        S_ADDR: if (bitcnt == 4'd8) begin
          bitcnt <= '0;
          if (shreg[7:1] == {ADDR_FIXED, addr_pins}) begin
            st     <= S_ACKA;
            sda_oe <= 1'b1;
            rw     <= shreg[0];
          end else st <= S_IGN;
        end
        S_ACKA: if (rw) begin
          st     <= S_RDAT;
          shreg  <= tx;
          sda_oe <= ~tx[7];
        end else begin
          st     <= S_WDAT;
          sda_oe <= 1'b0;
        end
        S_WDAT: if (bitcnt == 4'd8) begin
          bitcnt <= '0;
          pend   <= shreg[NCHAN-1:0];
          pend_v <= 1'b1;
          st     <= S_ACKW;
          sda_oe <= 1'b1;
        end
        S_ACKW: begin
          st     <= S_WDAT;
          sda_oe <= 1'b0;
        end
        S_RDAT: if (bitcnt == 4'd8) begin
          bitcnt <= '0;
          st     <= S_RACK;
          sda_oe <= 1'b0;
        end else begin
          sda_oe <= ~shreg[6];
          shreg  <= {shreg[6:0], 1'b0};
        end
        S_RACK: if (mack) begin
          st     <= S_RDAT;
          shreg  <= tx;
          sda_oe <= ~tx[7];
        end else st <= S_IGN;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_chan_select_chk.sv
module i2c_chan_select_chk #(
  parameter int NCHAN = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_f,
  input logic             start_det,
  input logic             stop_det,
  input logic [2:0]       st,
  input logic [3:0]       bitcnt,
  input logic             sda_oe,
  input logic [NCHAN-1:0] chan_en
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (chan_en == '0 && !sda_oe));

  assert_quiet_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 || st == 3'd7) |-> !sda_oe);

  assert_commit_at_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en) |-> $past(stop_det));

  assert_bit_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);

  assert_drive_while_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  assert_start_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> !sda_oe);
endmodule

bind i2c_chan_select i2c_chan_select_chk #(.NCHAN(NCHAN)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_det(start_det), .stop_det(stop_det),
  .st(st), .bitcnt(bitcnt), .sda_oe(sda_oe), .chan_en(chan_en)
);

// File: tb/test_i2c_chan_select.sv
module test_i2c_chan_select;
  localparam int T = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pins = 3'b101;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe;
  logic [3:0] chan_en;
  logic       sda_line;
  int         checks = 0, errors = 0;
  logic [3:0] model = 4'h0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_chan_select i_i2c_chan_select (
    .clk(clk), .rst_n(rst_n), .addr_pins(pins), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .chan_en(chan_en)
  );

  function automatic bit addr_hit(input logic [6:0] a, input logic [2:0] p);
    return a == {4'b1110, p};
  endfunction

  function automatic logic [7:0] read_val(input logic [3:0] sel);
    return {4'b0000, sel};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start;
    sda_m = 1; w(T); scl_m = 1; w(T); sda_m = 0; w(T); scl_m = 0; w(T);
  endtask

  task automatic i2c_stop;
    sda_m = 0; w(T); scl_m = 1; w(T); sda_m = 1; w(T);
  endtask

  task automatic wbit(input logic b, input bit glitch);
    sda_m = b;
    w(T / 2);
    if (glitch) begin scl_m = 1; w(2); scl_m = 0; end
    w(T / 2);
    scl_m = 1;
    w(T / 2);
    if (glitch && b) begin sda_m = 0; w(2); sda_m = 1; end
    w(T / 2);
    scl_m = 0;
    w(T / 2);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) wbit(b[i], glitch);
    sda_m = 1; w(T); scl_m = 1; w(T / 2);
    ack = !sda_line;
    w(T / 2); scl_m = 0; w(T);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; w(T); scl_m = 1; w(T / 2);
      b[i] = sda_line;
      w(T / 2); scl_m = 0; w(T / 2);
    end
    wbit(!give_ack, 1'b0);
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0h expected %0h", 0, 1);
    finish_up();
  end

  initial begin
    bit ack;
    logic [7:0] rd;
    void'($urandom(32'd7));
    w(5);
    chk(chan_en == 4'h0, "R1 enables in reset", 8'(chan_en), 8'h00);
    chk(sda_oe == 1'b0, "R1 sda released in reset", 8'(sda_oe), 8'h00);
    rst_n = 1;
    w(10);
    chk(chan_en == 4'h0, "R1 enables after reset", 8'(chan_en), 8'h00);

    // R2 R3 R5 R7: single write
    i2c_start();
    send_byte({4'b1110, pins, 1'b0}, 0, ack);
    chk(ack, "R2 address ack", 8'(ack), 8'h01);
    send_byte(8'h06, 0, ack);
    chk(ack, "R7 data ack low in ninth high", 8'(ack), 8'h01);
    chk(sda_oe == 1'b0, "R7 sda released after ack", 8'(sda_oe), 8'h00);
    chk(chan_en == 4'h0, "R3 pending before stop", 8'(chan_en), 8'h00);
    i2c_stop(); w(10); model = 4'h6;
    chk(chan_en == model, "R5 channels 1 and 2", 8'(chan_en), 8'(model));

    // R4: last byte wins, upper bits ignored
    i2c_start();
    send_byte({4'b1110, pins, 1'b0}, 0, ack);
    send_byte(8'h0F, 0, ack);
    send_byte(8'h03, 0, ack);
    send_byte(8'hF9, 0, ack);
    chk(chan_en == model, "R3 unchanged before stop", 8'(chan_en), 8'(model));
    i2c_stop(); w(10); model = 4'h9;
    chk(chan_en == model, "R4 last byte kept", 8'(chan_en), 8'(model));

    // R6: read with master ack repeats
    i2c_start();
    send_byte({4'b1110, pins, 1'b1}, 0, ack);
    chk(ack, "R6 read address ack", 8'(ack), 8'h01);
    recv_byte(1, rd);
    chk(rd == read_val(model), "R6 first read byte", rd, read_val(model));
    recv_byte(0, rd);
    chk(rd == read_val(model), "R6 repeated read byte", rd, read_val(model));
    i2c_stop(); w(10);

    // R2: mismatched address ignored
    i2c_start();
    send_byte({4'b1110, ~pins, 1'b0}, 0, ack);
    chk(!ack, "R2 no ack on mismatch", 8'(ack), 8'h00);
    send_byte(8'h0F, 0, ack);
    chk(!ack, "R2 data ignored after mismatch", 8'(ack), 8'h00);
    i2c_stop(); w(10);
    chk(chan_en == model, "R2 selection unchanged", 8'(chan_en), 8'(model));

    // R8: repeated start keeps selection pending
    i2c_start();
    send_byte({4'b1110, pins, 1'b0}, 0, ack);
    send_byte(8'h0C, 0, ack);
    i2c_start();
    send_byte({4'b1110, pins, 1'b1}, 0, ack);
    chk(ack, "R8 ack after repeated start", 8'(ack), 8'h01);
    recv_byte(0, rd);
    chk(rd == read_val(model), "R8 read shows old value", rd, read_val(model));
    chk(chan_en == model, "R8 not applied at repeated start", 8'(chan_en), 8'(model));
    i2c_stop(); w(10); model = 4'hC;
    chk(chan_en == model, "R8 applied at stop", 8'(chan_en), 8'(model));

    // R10: spikes on both lines
    i2c_start();
    send_byte({4'b1110, pins, 1'b0}, 1, ack);
    chk(ack, "R10 address through spikes", 8'(ack), 8'h01);
    send_byte(8'h0B, 1, ack);
    chk(ack, "R10 data ack through spikes", 8'(ack), 8'h01);
    i2c_stop(); w(10); model = 4'hB;
    chk(chan_en == model, "R10 value through spikes", 8'(chan_en), 8'(model));

    // R9: reset during a write
    i2c_start();
    send_byte({4'b1110, pins, 1'b0}, 0, ack);
    send_byte(8'h0F, 0, ack);
    rst_n = 0; w(4);
    chk(chan_en == 4'h0, "R9 reset clears selection", 8'(chan_en), 8'h00);
    chk(sda_oe == 1'b0, "R9 reset releases sda", 8'(sda_oe), 8'h00);
    rst_n = 1; w(10);
    i2c_stop(); w(10); model = 4'h0;
    chk(chan_en == model, "R9 pending dropped", 8'(chan_en), 8'(model));

    // random transfers
    for (int it = 0; it < 20; it++) begin
      logic [6:0] a;
      bit rd_op, hit;
      int nb;
      pins = 3'($urandom);
      a = ($urandom % 4 == 0) ? 7'($urandom) : {4'b1110, pins};
      hit = addr_hit(a, pins);
      rd_op = ($urandom % 4 == 0);
      nb = 1 + int'($urandom % 3);
      i2c_start();
      send_byte({a, rd_op}, 0, ack);
      chk(ack == hit, "R2 random address ack", 8'(ack), 8'(hit));
      if (rd_op) begin
        recv_byte(0, rd);
        if (hit) chk(rd == read_val(model), "R6 random read", rd, read_val(model));
      end else begin
        for (int k = 0; k < nb; k++) begin
          logic [7:0] d;
          d = 8'($urandom);
          send_byte(d, 0, ack);
          chk(ack == hit, "R4 random data ack", 8'(ack), 8'(hit));
          if (hit && k == nb - 1) begin
            chk(chan_en == model, "R3 random pending", 8'(chan_en), 8'(model));
            model = d[3:0];
          end
        end
      end
      i2c_stop(); w(10);
      chk(chan_en == model, "R5 random selection", 8'(chan_en), 8'(model));
    end

    finish_up();
  end
endmodule